// File: doc/BRIEF.md
# Multiplexed Converter Bus Sequencer

This block sits on the host side of a shared 10-bit parallel data bus. Several successive-approximation converters of the blank-and-convert type drive that bus. Each converter has one control line. Holding the line high blanks the converter's outputs and keeps it idle. Pulling the line low starts a conversion. The converter then reports completion on an active-low ready input. The sequencer drives all control lines, collects the ready flags, and reads the bus. It emits each captured word together with its channel number as a single-cycle sample strobe.

There are two operating modes, latched at the moment the block is enabled.

In shared-bus mode, every converter stays blanked except the one being converted or read. Channels are serviced in ascending round-robin order. As soon as the current channel reports ready, the following channel is started. Its conversion therefore overlaps the readout of the current word. The current channel is blanked at the capture edge, well inside the allowed overlap window.

In trigger mode, only converter 0 is used. Its line rests low so that its data stays on the bus. Each new conversion is triggered by a short high pulse.

In both modes, a line that has been raised is never lowered again until it has been high for a minimum blanking width. A channel whose ready flag never arrives is abandoned after a timeout and reported.

Top module: `adc_bus_sequencer`

## Requirements
- R1: While reset is asserted and directly after it, all control lines are high and no sample strobe or error strobe is asserted.
- R2: With the enable input low and any started conversion finished, all control lines are high and no further samples are produced.
- R3: In shared-bus mode (mode input 0 when enabled), channels are serviced round-robin from channel 0 upward. Exactly one line is lowered to start a channel's conversion.
- R4: The captured word is the bus value DV_DLY clock cycles after the cycle in which the ready input was first seen low. It is presented with a one-cycle strobe and the channel index, and that channel's line is high from the strobe cycle on.
- R5: In shared-bus mode the next channel is started while the previous word is still being read. Two lines are never low together for more than OVL_MAX consecutive cycles, and never more than two lines are low.
- R6: A control line that goes low has been high for at least BLANK_MIN consecutive cycles before.
- R7: If the ready input stays high for TIMEOUT cycles of a conversion, an error strobe with that channel index is issued, the line is raised, and the channel is skipped in favour of the next one.
- R8: In trigger mode (mode input 1 when enabled), only line 0 is ever lowered and all other lines stay high. Between conversions line 0 receives high pulses of exactly BLANK_MIN+1 cycles.
- R9: The mode input is sampled only when the block leaves the idle state; changing it during operation has no effect.
- R10: At most one converter drives the bus at any time, because each line is raised at capture before the next converter can finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| mode_i | input | 1 | 0 shared-bus mode, 1 trigger mode (latched on start) |
| drdy_ni | input | N_CH | Per-converter ready flag, active low |
| bus_i | input | DW | Shared converter data bus |
| bc_o | output | N_CH | Per-converter blank-and-convert line (high = blank) |
| smp_valid_o | output | 1 | Sample strobe |
| smp_ch_o | output | CW | Channel of the sample |
| smp_data_o | output | DW | Captured word |
| err_o | output | 1 | Timeout strobe |
| err_ch_o | output | CW | Channel that timed out |

## Verification
A wrong channel pointer shows on the next sample or error strobe as an out-of-order channel index, within one conversion time. A miscounted data-valid delay captures the bus before the converter drives it and returns a wrong word on the very next sample. A broken blanking counter shows at the first falling control line as a high period shorter than BLANK_MIN. A missed blank at capture shows within one conversion time, as two converters driving the bus together or an overlap window that keeps growing.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_CONV, ST_READ} seq_state_e;
  typedef enum logic {MODE_MUX = 1'b0, MODE_PULSE = 1'b1} seq_mode_e;
endpackage

// File: rtl/adc_seq_blank_guard.sv
module adc_seq_blank_guard #(
  parameter int BLANK_MIN = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic ready_o
);
  localparam int BW = $clog2(BLANK_MIN + 1);
  localparam logic [BW-1:0] B_MAX = BW'(BLANK_MIN);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!line_i)    cnt_q <= '0;
    else if (cnt_q != B_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = line_i && (cnt_q == B_MAX);

  // R6: a falling line had a full blanking period behind it
  p_blank_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_i) |-> cnt_q == B_MAX);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_CH    = 4,
  parameter int DW      = 10,
  parameter int DV_DLY  = 100,
  parameter int TIMEOUT = 10000,
  parameter int CW      = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            mode_i,
  input  logic [N_CH-1:0] drdy_ni,
  input  logic [DW-1:0]   bus_i,
  input  logic [N_CH-1:0] ready_i,
  output logic [N_CH-1:0] bc_o,
  output logic            smp_valid_o,
  output logic [CW-1:0]   smp_ch_o,
  output logic [DW-1:0]   smp_data_o,
  output logic            err_o,
  output logic [CW-1:0]   err_ch_o
);
  localparam int TMAX = (TIMEOUT > DV_DLY) ? TIMEOUT : DV_DLY;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_TO = TW'(TIMEOUT - 1);
  localparam logic [TW-1:0] T_DV = TW'(DV_DLY - 1);
  localparam logic [CW-1:0] LAST = CW'(N_CH - 1);

  seq_state_e      state_q;
  seq_mode_e       mode_q;
  logic [CW-1:0]   cur_q, nxt_ch;
  logic [TW-1:0]   tmr_q;
  logic [N_CH-1:0] bc_q;
  logic            pre_q, pre_go;

  always_comb begin
    if (mode_q == MODE_PULSE) nxt_ch = '0;
    else if (cur_q == LAST)   nxt_ch = '0;
    else                      nxt_ch = cur_q + 1'b1;
  end

  // start the following channel while the current word is still being read
  assign pre_go = (state_q == ST_READ) && (mode_q == MODE_MUX) && !pre_q && en_i &&
                  (nxt_ch != cur_q) && ready_i[nxt_ch];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_MUX;
      cur_q       <= '0;
      tmr_q       <= '0;
      bc_q        <= '1;
      pre_q       <= 1'b0;
      smp_valid_o <= 1'b0;
      smp_ch_o    <= '0;
      smp_data_o  <= '0;
      err_o       <= 1'b0;
      err_ch_o    <= '0;
    end else begin
      smp_valid_o <= 1'b0;
      err_o       <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          bc_q <= '1;
          if (en_i) begin
            mode_q  <= seq_mode_e'(mode_i);
            cur_q   <= '0;
            state_q <= ST_START;
          end
        end
        ST_START: begin
          if (!en_i) state_q <= ST_IDLE;
          else if (ready_i[cur_q]) begin
            bc_q[cur_q] <= 1'b0;
            tmr_q       <= '0;
            state_q     <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (!drdy_ni[cur_q]) begin
            tmr_q   <= '0;
            pre_q   <= 1'b0;
            state_q <= ST_READ;
          end else if (tmr_q == T_TO) begin
            bc_q[cur_q] <= 1'b1;
            err_o       <= 1'b1;
            err_ch_o    <= cur_q;
            cur_q       <= nxt_ch;
            state_q     <= ST_START;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_READ: begin
          if (pre_go) begin
            bc_q[nxt_ch] <= 1'b0;
            pre_q        <= 1'b1;
          end
          if (tmr_q == T_DV) begin
            smp_valid_o <= 1'b1;
            smp_ch_o    <= cur_q;
            smp_data_o  <= bus_i;
            bc_q[cur_q] <= 1'b1;
            cur_q       <= nxt_ch;
            tmr_q       <= '0;
            state_q     <= (pre_q || pre_go) ? ST_CONV : ST_START;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bc_o = bc_q;

  // R4: the captured channel is blanked in the strobe cycle
  p_capture_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> bc_o[smp_ch_o]);
  // R7: a timed-out channel is released
  p_timeout_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> bc_o[err_ch_o] && $past(state_q) == ST_CONV);
  // R3: while awaiting ready, the awaited line is low
  p_conv_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CONV |-> !bc_o[cur_q]);

  generate
    if (N_CH > 1) begin : g_side
      // R8: trigger mode keeps all other converters blanked
      p_pulse_side_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_q == MODE_PULSE |-> &bc_o[N_CH-1:1]);
    end
  endgenerate
endmodule

// File: rtl/adc_bus_sequencer.sv
module adc_bus_sequencer #(
  parameter int N_CH      = 4,
  parameter int DW        = 10,
  parameter int BLANK_MIN = 400,
  parameter int DV_DLY    = 100,
  parameter int TIMEOUT   = 10000,
  parameter int OVL_MAX   = 3000,
  parameter int CW        = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            mode_i,
  input  logic [N_CH-1:0] drdy_ni,
  input  logic [DW-1:0]   bus_i,
  output logic [N_CH-1:0] bc_o,
  output logic            smp_valid_o,
  output logic [CW-1:0]   smp_ch_o,
  output logic [DW-1:0]   smp_data_o,
  output logic            err_o,
  output logic [CW-1:0]   err_ch_o
);
  localparam int OW = $clog2(OVL_MAX + 2);
  localparam logic [OW-1:0] O_SAT = OW'(OVL_MAX + 1);

  logic [N_CH-1:0] ready;

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_guard
      adc_seq_blank_guard #(.BLANK_MIN(BLANK_MIN)) u_guard (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (bc_o[g]),
        .ready_o(ready[g])
      );
    end
  endgenerate

  adc_seq_ctrl #(
    .N_CH(N_CH), .DW(DW), .DV_DLY(DV_DLY), .TIMEOUT(TIMEOUT), .CW(CW)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .mode_i     (mode_i),
    .drdy_ni    (drdy_ni),
    .bus_i      (bus_i),
    .ready_i    (ready),
    .bc_o       (bc_o),
    .smp_valid_o(smp_valid_o),
    .smp_ch_o   (smp_ch_o),
    .smp_data_o (smp_data_o),
    .err_o      (err_o),
    .err_ch_o   (err_ch_o)
  );

  // overlap window monitor
  logic [OW-1:0] ovl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ovl_q <= '0;
    else if ($countones(~bc_o) < 2)     ovl_q <= '0;
    else if (ovl_q != O_SAT)            ovl_q <= ovl_q + 1'b1;
  end

  p_overlap_win_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_q <= OW'(OVL_MAX));
  p_two_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~bc_o) <= 2);
  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> &bc_o);
endmodule

// File: tb/adc_bus_sequencer_tb_top.sv
`timescale 1ns/1ps
module adc_bus_sequencer_tb_top;
  localparam int N    = 4;
  localparam int DW   = 10;
  localparam int BM   = 6;
  localparam int DV   = 3;
  localparam int TO   = 40;
  localparam int OVL  = 8;
  localparam int CONV = 20;
  localparam int OUTD = DV;
  localparam int CW   = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0, mode_i = 1'b0;
  logic [N-1:0] drdy_ni, bc_o, drv;
  logic [DW-1:0] bus_i, smp_data_o;
  logic smp_valid_o, err_o;
  logic [CW-1:0] smp_ch_o, err_ch_o;

  always #2.5 clk_i = ~clk_i;

  adc_bus_sequencer #(
    .N_CH(N), .DW(DW), .BLANK_MIN(BM), .DV_DLY(DV), .TIMEOUT(TO), .OVL_MAX(OVL)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
    .drdy_ni(drdy_ni), .bus_i(bus_i), .bc_o(bc_o),
    .smp_valid_o(smp_valid_o), .smp_ch_o(smp_ch_o), .smp_data_o(smp_data_o),
    .err_o(err_o), .err_ch_o(err_ch_o)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter models
  bit dead [N];
  int cc [N];
  int nc [N];
  logic [DW-1:0] wd [N];

  always @(posedge clk_i or negedge rst_ni) begin
    for (int k = 0; k < N; k++) begin
      if (!rst_ni) begin
        cc[k] <= 0; nc[k] <= 0; wd[k] <= '0; drdy_ni[k] <= 1'b1; drv[k] <= 1'b0;
      end else if (bc_o[k]) begin
        cc[k] <= 0; drdy_ni[k] <= 1'b1; drv[k] <= 1'b0;
      end else if (!dead[k]) begin
        cc[k] <= cc[k] + 1;
        if (cc[k] == CONV - 1) begin
          drdy_ni[k] <= 1'b0;
          wd[k] <= DW'((k * 181 + nc[k] * 37 + 11) % 1024);
          nc[k] <= nc[k] + 1;
        end
        if (cc[k] == CONV - 1 + OUTD) drv[k] <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_i = '0;
    for (int k = 0; k < N; k++) if (drv[k]) bus_i = bus_i | wd[k];
  end

  // behavioural reference, compared every cycle
  int ptr = 0, n_ev = 0, n_smp = 0, n_to = 0, ovl_run = 0, ovl_seen = 0;
  int hi_len [N];
  int seen [N];
  bit pm = 1'b0, armed = 1'b0, en_prev = 1'b0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (en_i && !en_prev) begin ptr = 0; armed = 1'b0; end
      en_prev = en_i;
      chk($countones(drv) <= 1, "R10", $countones(drv), 1);
      if ($countones(~bc_o) >= 2) begin ovl_run++; ovl_seen++; end else ovl_run = 0;
      chk(ovl_run <= OVL && $countones(~bc_o) <= 2, "R5", ovl_run, OVL);
      if (pm) chk(bc_o[N-1:1] == '1, "R8", int'(bc_o), 1);
      for (int k = 0; k < N; k++) begin
        if (bc_o[k]) hi_len[k]++;
        else begin
          if (hi_len[k] > 0) begin
            chk(hi_len[k] >= BM, "R6", hi_len[k], BM);
            if (pm && armed && k == 0) chk(hi_len[k] == BM + 1, "R8", hi_len[k], BM + 1);
          end
          hi_len[k] = 0;
        end
      end
      if (smp_valid_o) begin
        chk(int'(smp_ch_o) == ptr && !dead[ptr], "R3", smp_ch_o, ptr);
        chk(smp_data_o == wd[smp_ch_o], "R4", smp_data_o, wd[smp_ch_o]);
        seen[smp_ch_o]++;
        n_smp++; n_ev++; armed = 1'b1;
        ptr = pm ? 0 : (ptr + 1) % N;
      end
      if (err_o) begin
        chk(int'(err_ch_o) == ptr && dead[ptr], "R7", err_ch_o, ptr);
        n_to++; n_ev++;
        ptr = pm ? 0 : (ptr + 1) % N;
      end
    end
  end

  task automatic wait_ev(input int n);
    int tgt;
    tgt = n_ev + n;
    while (n_ev < tgt) @(negedge clk_i);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    int s0;
    for (int k = 0; k < N; k++) begin dead[k] = 1'b0; hi_len[k] = 0; seen[k] = 0; end
    repeat (3) @(negedge clk_i);
    chk(bc_o == '1 && !smp_valid_o && !err_o, "R1", int'(bc_o), 15);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(bc_o == '1 && !smp_valid_o && !err_o, "R1", int'(bc_o), 15);

    // shared-bus mode, mode input flipped mid-run (R9)
    pm = 1'b0; mode_i = 1'b0; en_i = 1'b1;
    wait_ev(3);
    mode_i = 1'b1;
    wait_ev(6);
    for (int k = 0; k < N; k++) chk(seen[k] >= 2, "R9", seen[k], 2);
    chk(ovl_seen > 0, "R5", ovl_seen, 1);

    // disable and drain
    en_i = 1'b0;
    repeat (150) @(negedge clk_i);
    s0 = n_smp;
    repeat (50) @(negedge clk_i);
    chk(bc_o == '1, "R2", int'(bc_o), 15);
    chk(n_smp == s0, "R2", n_smp, s0);

    // stuck channel 2
    dead[2] = 1'b1; mode_i = 1'b0;
    @(negedge clk_i); en_i = 1'b1;
    wait_ev(8);
    chk(n_to >= 2, "R7", n_to, 2);
    en_i = 1'b0;
    repeat (200) @(negedge clk_i);
    chk(bc_o == '1, "R2", int'(bc_o), 15);
    dead[2] = 1'b0;

    // trigger mode
    pm = 1'b1; mode_i = 1'b1;
    @(negedge clk_i); en_i = 1'b1;
    s0 = seen[0];
    wait_ev(4);
    chk(seen[0] == s0 + 4, "R8", seen[0], s0 + 4);
    en_i = 1'b0;
    repeat (200) @(negedge clk_i);
    pm = 1'b0;
    chk(bc_o == '1, "R2", int'(bc_o), 15);
    summary();
  end
endmodule